// File: doc/BRIEF.md
# Tape Byte/Word Packer

This block sits between a magnetic-tape data channel, which moves one 8-bit frame at a time, and a 16-bit system bus. In a read, tape frames arrive on a byte stream and leave as bus words. In a write, bus words arrive and leave as tape frames. Two packing formats are available. Byte format puts two frames in each word. Nibble format keeps only the low four bits of each frame and puts four of them in a word, so a tape written this way carries one nibble per frame.

Packing follows arrival order, so the same logic serves both tape directions. When the tape runs backwards, the frames reach the block last-first, and the first frame to arrive still lands in the lowest slot of the word. The block also keeps a 16-bit frame counter. During a read it counts the frames of the current record. During a write it advances from a value that software preloads. A status flag is armed by the preload and drops when the count wraps to zero. An error flag is raised when the bus asked for more bytes than the record supplied, or when a tape mark is reported during a read.

The mode inputs (`cfg_write`, `cfg_nibble`) and `bus_bytes` must be held steady for the whole of a record.

Top module: `tape_packer`

## Requirements
- R1: In byte format read, each word takes the first-arriving frame in bits 7:0 and the second in bits 15:8. This holds whichever way the tape is moving.
- R2: In nibble format read, each word takes bits 3:0 of four successive frames. The first goes to bits 3:0 and the fourth to bits 15:12, and bits 7:4 of every frame are ignored.
- R3: If a frame marked last completes only part of a word, that word is still emitted, with every unfilled slot zero. `bus_out_last` is high on that word and only on that word.
- R4: In byte format write, each word is emitted as its bits 7:0 frame and then its bits 15:8 frame. `tp_out_last` is high only on the final frame of a word that was marked last.
- R5: In nibble format write, each word becomes four frames, taken from bits 3:0 first up to bits 15:12. The nibble sits in bits 3:0 of each frame and bits 7:4 are zero.
- R6: In read mode, `rec_start` sets the frame count to zero. Each accepted frame adds one, so after the record the count equals its length modulo 2^16.
- R7: When the last frame of a read record is accepted, `fc_error` is set on the next cycle if `bus_bytes` exceeds the record length (byte format) or half the record length rounded up (nibble format). A `tmark` pulse in read mode also sets `fc_error`, and `rec_start` clears it.
- R8: A pulse on `fc_wr` loads `fc_wr_data` into the frame count and sets `fc_status`. Each frame emitted in write mode adds one, modulo 2^16. `fc_status` clears when an increment brings the count to zero.
- R9: Any output held valid without ready keeps its data and last flag unchanged. No frame or word is dropped or duplicated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write | input | 1 | 1 = write (word to frame), 0 = read |
| cfg_nibble | input | 1 | 1 = nibble format, 0 = byte format |
| rec_start | input | 1 | Pulse before a record; clears the packer, the error flag and (in read mode) the count |
| tmark | input | 1 | Tape mark seen during a read |
| bus_bytes | input | 16 | Byte count requested by the bus for this record |
| fc_wr | input | 1 | Load the frame counter |
| fc_wr_data | input | 16 | Value loaded by fc_wr |
| tp_in_valid | input | 1 | Read frame valid |
| tp_in_ready | output | 1 | Read frame accepted |
| tp_in_data | input | 8 | Read frame |
| tp_in_last | input | 1 | Final frame of the record |
| bus_out_valid | output | 1 | Packed word valid |
| bus_out_ready | input | 1 | Bus takes the word |
| bus_out_data | output | 16 | Packed word |
| bus_out_last | output | 1 | Final word of the record |
| bus_in_valid | input | 1 | Write word valid |
| bus_in_ready | output | 1 | Write word accepted |
| bus_in_data | input | 16 | Write word |
| bus_in_last | input | 1 | Final word of the record |
| tp_out_valid | output | 1 | Write frame valid |
| tp_out_ready | input | 1 | Tape takes the frame |
| tp_out_data | output | 8 | Write frame |
| tp_out_last | output | 1 | Final frame of the record |
| frame_count | output | 16 | Frame counter |
| fc_status | output | 1 | Preload armed, cleared on wrap to zero |
| fc_error | output | 1 | Frame count error |

## Verification
The checker watches several rules on every cycle: stalled outputs stay stable, write frames in nibble format carry zero upper bits, a preload and a read record start leave the counter in the right state, a tape mark raises the error, and the status flag only drops when the count is zero. What only the bench scenarios can show is whether the packed and unpacked data is correct: slot order in both formats, zero fill of partial words, placement of the last flag, the final frame count, and the error decision at its exact boundary. To show these, the bench compares whole records against words and frames it computes itself, with random stalls on both sides.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
  localparam int TPK_WORD_W = 16;
  localparam int TPK_BYTE_W = 8;
  localparam int TPK_NIB_W  = 4;
  localparam int TPK_CNT_W  = 16;
endpackage

// File: rtl/tpk_pack.sv
module tpk_pack #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nib,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam int BPW = WORD_W / BYTE_W;
  localparam int NPW = WORD_W / NIB_W;
  localparam int IW  = (NPW > 1) ? $clog2(NPW) : 1;

  logic [WORD_W-1:0] acc, merged;
  logic [IW-1:0]     idx;
  logic              full, accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign full     = nib ? (idx == IW'(NPW-1)) : (idx == IW'(BPW-1));

  always_comb begin
    merged = acc;
    for (int j = 0; j < NPW; j++)
      if (nib && idx == IW'(j)) merged[j*NIB_W +: NIB_W] = in_data[NIB_W-1:0];
    for (int j = 0; j < BPW; j++)
      if (!nib && idx == IW'(j)) merged[j*BYTE_W +: BYTE_W] = in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; idx <= '0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (accept) begin
        if (full || in_last) begin
          out_valid <= 1'b1;
          out_data  <= merged;
          out_last  <= in_last;
          acc <= '0; idx <= '0;
        end else begin
          acc <= merged;
          idx <= idx + 1'b1;
        end
      end else if (clr) begin
        acc <= '0; idx <= '0;
      end
    end
  end
endmodule

// File: rtl/tpk_unpack.sv
module tpk_unpack #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nib,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  localparam int BPW = WORD_W / BYTE_W;
  localparam int NPW = WORD_W / NIB_W;
  localparam int IW  = (NPW > 1) ? $clog2(NPW) : 1;

  logic [WORD_W-1:0] hold;
  logic              have, hlast, last_unit, slot_free;
  logic [IW-1:0]     idx;
  logic [BYTE_W-1:0] unit;

  assign in_ready  = !have;
  assign slot_free = !out_valid || out_ready;
  assign last_unit = nib ? (idx == IW'(NPW-1)) : (idx == IW'(BPW-1));

  always_comb begin
    unit = '0;
    for (int j = 0; j < NPW; j++)
      if (nib && idx == IW'(j)) unit[NIB_W-1:0] = hold[j*NIB_W +: NIB_W];
    for (int j = 0; j < BPW; j++)
      if (!nib && idx == IW'(j)) unit = hold[j*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have <= 1'b0; hold <= '0; hlast <= 1'b0; idx <= '0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (have && slot_free) begin
        out_valid <= 1'b1;
        out_data  <= unit;
        out_last  <= hlast && last_unit;
        if (last_unit) begin
          have <= 1'b0; idx <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (in_valid && !have) begin
        have <= 1'b1; hold <= in_data; hlast <= in_last; idx <= '0;
      end
    end
  end
endmodule

// File: rtl/tpk_fcount.sv
module tpk_fcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             write_mode,
  input  logic             nib,
  input  logic             rec_start,
  input  logic             tmark,
  input  logic [CNT_W-1:0] bus_bytes,
  input  logic             fc_wr,
  input  logic [CNT_W-1:0] fc_wr_data,
  input  logic             rd_inc,
  input  logic             rd_last,
  input  logic             wr_inc,
  output logic [CNT_W-1:0] count,
  output logic             fcs,
  output logic             fce
);
  localparam int CW1 = CNT_W + 1;

  logic [CNT_W-1:0] cnt_inc;
  logic [CW1-1:0]   half_len;
  logic             short_rec, step;

  assign cnt_inc   = count + 1'b1;
  assign half_len  = (CW1'(cnt_inc) + CW1'(1)) >> 1;
  assign short_rec = nib ? (CW1'(bus_bytes) > half_len) : (bus_bytes > cnt_inc);
  assign step      = write_mode ? wr_inc : rd_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0; fcs <= 1'b0; fce <= 1'b0;
    end else begin
      if (fc_wr) begin
        count <= fc_wr_data;
        fcs   <= 1'b1;
      end else if (rec_start && !write_mode) begin
        count <= '0;
      end else if (step) begin
        count <= cnt_inc;
        if (write_mode && cnt_inc == '0) fcs <= 1'b0;
      end
      if (rec_start)
        fce <= 1'b0;
      else if (!write_mode && (tmark || (rd_inc && rd_last && short_rec)))
        fce <= 1'b1;
    end
  end
endmodule

// File: rtl/tape_packer.sv
module tape_packer
  import tpk_pkg::*;
#(
  parameter int WORD_W = TPK_WORD_W,
  parameter int BYTE_W = TPK_BYTE_W,
  parameter int NIB_W  = TPK_NIB_W,
  parameter int CNT_W  = TPK_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_write,
  input  logic              cfg_nibble,
  input  logic              rec_start,
  input  logic              tmark,
  input  logic [CNT_W-1:0]  bus_bytes,
  input  logic              fc_wr,
  input  logic [CNT_W-1:0]  fc_wr_data,
  input  logic              tp_in_valid,
  output logic              tp_in_ready,
  input  logic [BYTE_W-1:0] tp_in_data,
  input  logic              tp_in_last,
  output logic              bus_out_valid,
  input  logic              bus_out_ready,
  output logic [WORD_W-1:0] bus_out_data,
  output logic              bus_out_last,
  input  logic              bus_in_valid,
  output logic              bus_in_ready,
  input  logic [WORD_W-1:0] bus_in_data,
  input  logic              bus_in_last,
  output logic              tp_out_valid,
  input  logic              tp_out_ready,
  output logic [BYTE_W-1:0] tp_out_data,
  output logic              tp_out_last,
  output logic [CNT_W-1:0]  frame_count,
  output logic              fc_status,
  output logic              fc_error
);
  logic pk_ready, up_ready, rd_valid, wr_valid;

  assign rd_valid     = tp_in_valid && !cfg_write;
  assign wr_valid     = bus_in_valid && cfg_write;
  assign tp_in_ready  = pk_ready && !cfg_write;
  assign bus_in_ready = up_ready && cfg_write;

  tpk_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_pack (
    .clk(clk), .rst(rst), .nib(cfg_nibble), .clr(rec_start),
    .in_valid(rd_valid), .in_ready(pk_ready), .in_data(tp_in_data), .in_last(tp_in_last),
    .out_valid(bus_out_valid), .out_ready(bus_out_ready),
    .out_data(bus_out_data), .out_last(bus_out_last)
  );

  tpk_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_unpack (
    .clk(clk), .rst(rst), .nib(cfg_nibble),
    .in_valid(wr_valid), .in_ready(up_ready), .in_data(bus_in_data), .in_last(bus_in_last),
    .out_valid(tp_out_valid), .out_ready(tp_out_ready),
    .out_data(tp_out_data), .out_last(tp_out_last)
  );

  tpk_fcount #(.CNT_W(CNT_W)) u_fcount (
    .clk(clk), .rst(rst), .write_mode(cfg_write), .nib(cfg_nibble),
    .rec_start(rec_start), .tmark(tmark), .bus_bytes(bus_bytes),
    .fc_wr(fc_wr), .fc_wr_data(fc_wr_data),
    .rd_inc(rd_valid && pk_ready), .rd_last(tp_in_last),
    .wr_inc(tp_out_valid && tp_out_ready),
    .count(frame_count), .fcs(fc_status), .fce(fc_error)
  );
endmodule

// File: rtl/tpk_checker.sv
module tpk_checker #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_write,
  input logic              cfg_nibble,
  input logic              rec_start,
  input logic              tmark,
  input logic              fc_wr,
  input logic [CNT_W-1:0]  fc_wr_data,
  input logic              bus_out_valid,
  input logic              bus_out_ready,
  input logic [WORD_W-1:0] bus_out_data,
  input logic              bus_out_last,
  input logic              tp_out_valid,
  input logic              tp_out_ready,
  input logic [BYTE_W-1:0] tp_out_data,
  input logic              tp_out_last,
  input logic [CNT_W-1:0]  frame_count,
  input logic              fc_status,
  input logic              fc_error
);
  assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
    bus_out_valid && !bus_out_ready |=> bus_out_valid && $stable(bus_out_data) && $stable(bus_out_last));

  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (rst)
    tp_out_valid && !tp_out_ready |=> tp_out_valid && $stable(tp_out_data) && $stable(tp_out_last));

  assert_nib_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    tp_out_valid && cfg_nibble |-> (tp_out_data >> NIB_W) == '0);

  assert_status_drop_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(fc_status) |-> frame_count == '0);

  assert_preload_R8: assert property (@(posedge clk) disable iff (rst)
    fc_wr |=> fc_status && frame_count == $past(fc_wr_data));

  assert_read_start_R6: assert property (@(posedge clk) disable iff (rst)
    rec_start && !cfg_write && !fc_wr |=> frame_count == '0);

  assert_tmark_R7: assert property (@(posedge clk) disable iff (rst)
    tmark && !cfg_write && !rec_start |=> fc_error);
endmodule

bind tape_packer tpk_checker #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tape_packer.sv
module tb_tape_packer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_write = 1'b0, cfg_nibble = 1'b0, rec_start = 1'b0, tmark = 1'b0;
  logic [15:0] bus_bytes = '0, fc_wr_data = '0;
  logic fc_wr = 1'b0;
  logic tp_in_valid = 1'b0, tp_in_last = 1'b0, tp_in_ready;
  logic [7:0] tp_in_data = '0;
  logic bus_out_valid, bus_out_ready = 1'b0, bus_out_last;
  logic [15:0] bus_out_data;
  logic bus_in_valid = 1'b0, bus_in_last = 1'b0, bus_in_ready;
  logic [15:0] bus_in_data = '0;
  logic tp_out_valid, tp_out_ready = 1'b0, tp_out_last;
  logic [7:0] tp_out_data;
  logic [15:0] frame_count;
  logic fc_status, fc_error;

  int n_checks = 0, n_fail = 0;
  logic [15:0] got_w[$];
  logic        got_wl[$];
  logic [7:0]  got_b[$];
  logic        got_bl[$];

  always #2.5 clk = ~clk;

  tape_packer dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // collectors with random backpressure
  initial begin
    forever begin
      @(negedge clk);
      bus_out_ready = ($urandom % 4) != 0;
      tp_out_ready  = ($urandom % 4) != 0;
      #1;
      if (bus_out_valid && bus_out_ready) begin got_w.push_back(bus_out_data); got_wl.push_back(bus_out_last); end
      if (tp_out_valid && tp_out_ready) begin got_b.push_back(tp_out_data); got_bl.push_back(tp_out_last); end
    end
  end

  function automatic logic [15:0] pack_exp(input logic [7:0] d[$], input int k, input bit nib);
    logic [15:0] w = '0;
    int per = nib ? 4 : 2;
    for (int j = 0; j < per; j++) begin
      int i = k * per + j;
      if (i < d.size()) begin
        if (nib) w[j*4 +: 4] = d[i][3:0];
        else     w[j*8 +: 8] = d[i];
      end
    end
    return w;
  endfunction

  task automatic run_read(input int len, input bit nib, input logic [15:0] bb, input bit rand_data);
    logic [7:0] d[$];
    int per = nib ? 4 : 2;
    int nw = (len + per - 1) / per;
    bit hs;
    bit fce_exp;
    cfg_write = 1'b0; cfg_nibble = nib; bus_bytes = bb;
    got_w.delete(); got_wl.delete();
    @(negedge clk) rec_start = 1'b1;
    @(negedge clk) rec_start = 1'b0;
    chk(frame_count == 16'd0, "R6 count cleared at start", frame_count, 0);
    for (int i = 0; i < len; i++) d.push_back(rand_data ? 8'($urandom) : 8'(8'hA0 + i));
    for (int i = 0; i < len; i++) begin
      repeat ($urandom % 2) @(negedge clk);
      tp_in_valid = 1'b1; tp_in_data = d[i]; tp_in_last = (i == len - 1);
      do begin #1; hs = tp_in_ready; @(negedge clk); end while (!hs);
      tp_in_valid = 1'b0; tp_in_last = 1'b0;
    end
    for (int t = 0; t < 200 && got_w.size() < nw; t++) @(negedge clk);
    chk(got_w.size() == nw, "R9 word count", got_w.size(), nw);
    for (int k = 0; k < nw && k < got_w.size(); k++) begin
      logic [15:0] e = pack_exp(d, k, nib);
      chk(got_w[k] == e, nib ? "R2 nibble word" : "R1 byte word", got_w[k], e);
      chk(got_wl[k] == (k == nw - 1), "R3 last flag on word", got_wl[k], (k == nw - 1));
    end
    chk(frame_count == 16'(len), "R6 record length", frame_count, len);
    fce_exp = nib ? (bb > 16'((len + 1) / 2)) : (bb > 16'(len));
    chk(fc_error == fce_exp, "R7 frame count error", fc_error, fce_exp);
  endtask

  task automatic run_write(input int nw, input bit nib, input logic [15:0] fcv);
    logic [15:0] w[$];
    int per = nib ? 4 : 2;
    int nb = nw * per;
    bit hs;
    bit fcs_exp = 1'b1;
    logic [15:0] c;
    cfg_write = 1'b1; cfg_nibble = nib;
    got_b.delete(); got_bl.delete();
    @(negedge clk) begin fc_wr = 1'b1; fc_wr_data = fcv; end
    @(negedge clk) fc_wr = 1'b0;
    chk(frame_count == fcv && fc_status, "R8 preload", {fc_status, frame_count}, {1'b1, fcv});
    for (int i = 0; i < nw; i++) w.push_back(16'($urandom));
    for (int i = 0; i < nw; i++) begin
      repeat ($urandom % 2) @(negedge clk);
      bus_in_valid = 1'b1; bus_in_data = w[i]; bus_in_last = (i == nw - 1);
      do begin #1; hs = bus_in_ready; @(negedge clk); end while (!hs);
      bus_in_valid = 1'b0; bus_in_last = 1'b0;
    end
    for (int t = 0; t < 300 && got_b.size() < nb; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(got_b.size() == nb, "R9 frame count out", got_b.size(), nb);
    for (int i = 0; i < nb && i < got_b.size(); i++) begin
      logic [7:0] e = nib ? {4'h0, w[i/4][(i%4)*4 +: 4]} : w[i/2][(i%2)*8 +: 8];
      chk(got_b[i] == e, nib ? "R5 nibble frame" : "R4 byte frame", got_b[i], e);
      chk(got_bl[i] == (i == nb - 1), "R4 last flag on frame", got_bl[i], (i == nb - 1));
    end
    c = fcv;
    for (int i = 0; i < nb; i++) begin c = c + 16'd1; if (c == 16'd0) fcs_exp = 1'b0; end
    chk(frame_count == c, "R8 count after write", frame_count, c);
    chk(fc_status == fcs_exp, "R8 status after write", fc_status, fcs_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_out_valid && !tp_out_valid, "R9 outputs idle after reset", {bus_out_valid, tp_out_valid}, 0);
    chk(frame_count == 0 && !fc_status && !fc_error, "R8 counter state after reset",
        {fc_error, fc_status, frame_count}, 0);
    // directed corners
    run_read(1, 1'b0, 16'd1, 1'b0);   // R3 single frame, high half zero, no error
    run_read(5, 1'b1, 16'd3, 1'b0);   // R3 nibble partial word, 3 bytes == ceil(5/2), no error
    run_read(5, 1'b1, 16'd4, 1'b1);   // R7 one over the nibble limit
    run_read(4, 1'b0, 16'd4, 1'b1);   // R7 exact boundary
    run_read(4, 1'b0, 16'd5, 1'b1);   // R7 one over
    // R7 tape mark
    @(negedge clk) tmark = 1'b1;
    @(negedge clk) tmark = 1'b0;
    chk(fc_error == 1'b1, "R7 tape mark sets error", fc_error, 1);
    @(negedge clk) rec_start = 1'b1;
    @(negedge clk) rec_start = 1'b0;
    chk(fc_error == 1'b0, "R7 start clears error", fc_error, 0);
    // random reads
    for (int r = 0; r < 8; r++)
      run_read(1 + ($urandom % 13), 1'($urandom), 16'($urandom % 16), 1'b1);
    // writes: exact wrap, no wrap, random
    run_write(3, 1'b0, 16'hFFFA);     // R8 reaches zero exactly
    run_write(2, 1'b1, 16'h0100);     // R8 stays armed
    run_write(2, 1'b1, 16'hFFFC);     // R8 wraps mid-record then keeps counting
    for (int r = 0; r < 4; r++)
      run_write(1 + ($urandom % 5), 1'($urandom), 16'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule